// File: doc/BRIEF.md
# Sync-Aligned Programmable Clock Divider

This block produces a one-cycle clock-enable pulse once every N input clock cycles, where N is set from 1 to 8 through a small register port. An external sync pulse can pull the divider's phase back to a known point, so that several dividers fed the same pulse run in step. Whether a pulse is allowed through is decided by three control bits: a master enable that must be on for anything sync-related to happen, a gating enable that passes pulses to the divider, and a single-shot flag that lets just the first pulse through and then drops the gating enable by itself.

The sync input is resynchronised through a flop chain and only its rising edges are used. Each accepted edge restarts the divider count at zero, produces a one-cycle realign pulse and sets a sticky status bit that software clears by writing one. A small mode state machine tracks the control bits with four states: `ST_OFF` (master enable low), `ST_BLOCKED` (master on, gating off), `ST_CONT` (master and gating on, single-shot off) and `ST_ONCE` (all three on). Writes to the control register move it between any two states; an accepted edge in `ST_ONCE` moves it to `ST_BLOCKED` unless the same cycle's write sets the gating bit again.

Top module: `clkdiv_sync`

## Requirements
- R1: Address 0 is the control register with bit 0 master enable, bit 1 gating enable, bit 2 single-shot flag, bits 7..3 reading zero; address 1 holds the ratio field in bits 2..0 (ratio = field + 1, upper bits read zero); address 2 holds the sticky status in bit 0; address 3 reads zero.
- R2: While the master enable is low, sync pulses have no effect on the divider, the realign output or the status, and the edge detector is held cleared.
- R3: A sync edge is accepted only when both the master enable and the gating enable are high.
- R4: With the single-shot flag low, every accepted rising edge realigns the divider.
- R5: With the single-shot flag high, the first accepted edge realigns, the gating enable then reads zero, and later pulses are ignored until software sets it again.
- R6: A control write in the same cycle as the single-shot automatic clear takes precedence, so a write with bit 1 set leaves the gating enable set.
- R7: A sync_in rising edge first seen at clock edge k gives, after clock edge k+2, a counter of zero (div_en_o high) and realign_o high for exactly one cycle; a sync level held high gives only one realignment.
- R8: div_en_o is high when the counter is zero and repeats every field+1 cycles; field 0 makes it high every cycle.
- R9: The status bit is set on every realignment and cleared by writing 1 to address 2 bit 0; writing 0 leaves it, and a set in the same cycle as a clear wins.
- R10: Synchronous active-high reset clears all control bits, the status bit, the ratio field (ratio 1) and the counter, so div_en_o is high right after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address for write and read |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| sync_in | input | 1 | Asynchronous sync pulse |
| div_en_o | output | 1 | Divided clock-enable pulse |
| realign_o | output | 1 | One-cycle pulse after each realignment |
| sticky_o | output | 1 | Sticky realignment status |

## Verification
The bench builds the block with its default parameters: two synchroniser stages, a 3-bit ratio field and an 8-bit data path. These make every ratio from 1 to 8 reachable, so a table walks all eight and compares sixteen cycles of the enable pattern after a realignment. With two stages the edge-to-realign latency is short and fixed, so the same-cycle collisions (single-shot clear against a control write, status set against a status clear) can be hit exactly by timing the write one cycle after the pulse.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

    typedef enum logic [1:0] {
        ST_OFF     = 2'd0,
        ST_BLOCKED = 2'd1,
        ST_CONT    = 2'd2,
        ST_ONCE    = 2'd3
    } sync_mode_e;

    localparam int unsigned CTRL_ADDR  = 0;
    localparam int unsigned RATIO_ADDR = 1;
    localparam int unsigned STAT_ADDR  = 2;

    localparam int unsigned MASTER_BIT = 0;
    localparam int unsigned GATE_BIT   = 1;
    localparam int unsigned ONCE_BIT   = 2;
    localparam int unsigned CTRL_BITS  = 3;

    function automatic sync_mode_e classify_mode(input logic m, input logic g, input logic o);
        if (!m)
            return ST_OFF;
        else if (!g)
            return ST_BLOCKED;
        else if (o)
            return ST_ONCE;
        else
            return ST_CONT;
    endfunction

endpackage

// File: rtl/cds_sync_edge.sv
module cds_sync_edge #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic sync_in,
    output logic rise_o
);
    localparam int unsigned DEPTH = STAGES + 1;

    logic [DEPTH-1:0] pipe_q;

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst || !enable)
                        pipe_q[0] <= 1'b0;
                    else
                        pipe_q[0] <= sync_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst || !enable)
                        pipe_q[g] <= 1'b0;
                    else
                        pipe_q[g] <= pipe_q[g-1];
                end
            end
        end
    endgenerate

    // newest synchronised sample high, one older sample low
    assign rise_o = pipe_q[STAGES-1] & ~pipe_q[STAGES];

endmodule

// File: rtl/cds_mode_fsm.sv
module cds_mode_fsm
    import clkdiv_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       master_d,
    input  logic       gate_d,
    input  logic       once_d,
    input  logic       edge_rise,
    output logic       realign,
    output logic       once_fire,
    output sync_mode_e state_o
);
    sync_mode_e state_q;
    sync_mode_e state_d;

    always_comb begin
        state_d = classify_mode(master_d, gate_d, once_d);
    end

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= ST_OFF;
        else
            state_q <= state_d;
    end

    always_comb begin
        realign   = 1'b0;
        once_fire = 1'b0;
        unique case (state_q)
            ST_OFF: begin
                realign   = 1'b0;
                once_fire = 1'b0;
            end
            ST_BLOCKED: begin
                realign   = 1'b0;
                once_fire = 1'b0;
            end
            ST_CONT: begin
                realign   = edge_rise;
                once_fire = 1'b0;
            end
            ST_ONCE: begin
                realign   = edge_rise;
                once_fire = edge_rise;
            end
        endcase
    end

    assign state_o = state_q;

endmodule

// File: rtl/cds_regs.sv
module cds_regs
    import clkdiv_pkg::*;
#(
    parameter int unsigned ADDR_W  = 2,
    parameter int unsigned DATA_W  = 8,
    parameter int unsigned RATIO_W = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    input  logic               auto_clr_gate,
    input  logic               realign_set,
    output logic [DATA_W-1:0]  rdata,
    output logic               master_q,
    output logic               gate_q,
    output logic               once_q,
    output logic               master_d,
    output logic               gate_d,
    output logic               once_d,
    output logic [RATIO_W-1:0] ratio_q,
    output logic               sticky_q
);
    localparam int unsigned LOW_W = (RATIO_W > CTRL_BITS) ? RATIO_W : CTRL_BITS;

    logic ctrl_wr;
    logic ratio_wr;
    logic stat_wr;
    logic unused_wdata;

    assign ctrl_wr  = wr_en && (addr == ADDR_W'(CTRL_ADDR));
    assign ratio_wr = wr_en && (addr == ADDR_W'(RATIO_ADDR));
    assign stat_wr  = wr_en && (addr == ADDR_W'(STAT_ADDR));
    assign unused_wdata = ^wdata[DATA_W-1:LOW_W];

    always_comb begin
        master_d = master_q;
        gate_d   = gate_q;
        once_d   = once_q;
        if (auto_clr_gate)
            gate_d = 1'b0;
        if (ctrl_wr) begin
            master_d = wdata[MASTER_BIT];
            gate_d   = wdata[GATE_BIT];
            once_d   = wdata[ONCE_BIT];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            master_q <= 1'b0;
            gate_q   <= 1'b0;
            once_q   <= 1'b0;
        end else begin
            master_q <= master_d;
            gate_q   <= gate_d;
            once_q   <= once_d;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            ratio_q <= '0;
        else if (ratio_wr)
            ratio_q <= wdata[RATIO_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst)
            sticky_q <= 1'b0;
        else if (realign_set)
            sticky_q <= 1'b1;
        else if (stat_wr && wdata[0])
            sticky_q <= 1'b0;
    end

    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(CTRL_ADDR)) begin
            rdata[MASTER_BIT] = master_q;
            rdata[GATE_BIT]   = gate_q;
            rdata[ONCE_BIT]   = once_q;
        end else if (addr == ADDR_W'(RATIO_ADDR)) begin
            rdata[RATIO_W-1:0] = ratio_q;
        end else if (addr == ADDR_W'(STAT_ADDR)) begin
            rdata[0] = sticky_q;
        end
    end

endmodule

// File: rtl/cds_divider.sv
module cds_divider #(
    parameter int unsigned RATIO_W = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               realign,
    input  logic [RATIO_W-1:0] ratio_m1,
    output logic               en_o
);
    logic [RATIO_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (realign)
            cnt_q <= '0;
        else if (cnt_q >= ratio_m1)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    assign en_o = (cnt_q == '0);

endmodule

// File: rtl/clkdiv_sync.sv
module clkdiv_sync
    import clkdiv_pkg::*;
#(
    parameter int unsigned ADDR_W      = 2,
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned RATIO_W     = 3,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              sync_in,
    output logic              div_en_o,
    output logic              realign_o,
    output logic              sticky_o
);
    logic               ctrl_master;
    logic               ctrl_gate;
    logic               ctrl_once;
    logic               master_d;
    logic               gate_d;
    logic               once_d;
    logic [RATIO_W-1:0] ratio_m1;
    logic               edge_rise;
    logic               realign;
    logic               once_fire;
    logic               realign_q;
    sync_mode_e         mode;
    logic               unused_mode;

    assign unused_mode = ^mode;

    cds_regs #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .RATIO_W(RATIO_W)
    ) u_regs (
        .clk          (clk),
        .rst          (rst),
        .wr_en        (wr_en),
        .addr         (reg_addr),
        .wdata        (reg_wdata),
        .auto_clr_gate(once_fire),
        .realign_set  (realign),
        .rdata        (reg_rdata),
        .master_q     (ctrl_master),
        .gate_q       (ctrl_gate),
        .once_q       (ctrl_once),
        .master_d     (master_d),
        .gate_d       (gate_d),
        .once_d       (once_d),
        .ratio_q      (ratio_m1),
        .sticky_q     (sticky_o)
    );

    cds_sync_edge #(
        .STAGES(SYNC_STAGES)
    ) u_edge (
        .clk    (clk),
        .rst    (rst),
        .enable (ctrl_master),
        .sync_in(sync_in),
        .rise_o (edge_rise)
    );

    cds_mode_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .master_d (master_d),
        .gate_d   (gate_d),
        .once_d   (once_d),
        .edge_rise(edge_rise),
        .realign  (realign),
        .once_fire(once_fire),
        .state_o  (mode)
    );

    cds_divider #(
        .RATIO_W(RATIO_W)
    ) u_div (
        .clk     (clk),
        .rst     (rst),
        .realign (realign),
        .ratio_m1(ratio_m1),
        .en_o    (div_en_o)
    );

    always_ff @(posedge clk) begin
        if (rst)
            realign_q <= 1'b0;
        else
            realign_q <= realign;
    end

    assign realign_o = realign_q;

endmodule

// File: rtl/clkdiv_sync_chk.sv
module clkdiv_sync_chk #(
    parameter int unsigned ADDR_W  = 2,
    parameter int unsigned DATA_W  = 8,
    parameter int unsigned RATIO_W = 3
) (
    input logic               clk,
    input logic               rst,
    input logic               wr_en,
    input logic [ADDR_W-1:0]  reg_addr,
    input logic [DATA_W-1:0]  reg_rdata,
    input logic               div_en_o,
    input logic               realign_o,
    input logic               sticky_o,
    input logic               ctrl_master,
    input logic               ctrl_gate,
    input logic               ctrl_once,
    input logic [RATIO_W-1:0] ratio_m1,
    input logic               edge_rise
);
    p_reserved_zero_r1: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == '0) |-> (reg_rdata[DATA_W-1:3] == '0));

    p_idle_detector_r2: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_master && !$past(ctrl_master)) |-> !edge_rise);

    p_needs_both_r3: assert property (@(posedge clk) disable iff (rst)
        realign_o |-> $past(ctrl_master && ctrl_gate));

    p_once_clears_r5: assert property (@(posedge clk) disable iff (rst)
        (realign_o && $past(ctrl_once) && !$past(wr_en && (reg_addr == '0))) |-> !ctrl_gate);

    p_phase_zero_r7: assert property (@(posedge clk) disable iff (rst)
        realign_o |-> div_en_o);

    p_ratio_one_r8: assert property (@(posedge clk) disable iff (rst)
        ((ratio_m1 == '0) && $past(ratio_m1 == '0)) |-> div_en_o);

    p_status_set_r9: assert property (@(posedge clk) disable iff (rst)
        realign_o |-> sticky_o);

    p_reset_phase_r10: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (div_en_o && !sticky_o && !ctrl_master));

endmodule

bind clkdiv_sync clkdiv_sync_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .RATIO_W(RATIO_W)
) u_chk (.*);

// File: tb/clkdiv_sync_bench.sv
module clkdiv_sync_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       sync_in = 1'b0;
    logic       div_en_o;
    logic       realign_o;
    logic       sticky_o;

    int total = 0;
    int bad = 0;

    // {ratio field, 16-cycle enable pattern, bit i = cycle i after realign}
    localparam logic [18:0] VEC [8] = '{
        {3'd0, 16'hFFFF}, {3'd1, 16'h5555}, {3'd2, 16'h9249}, {3'd3, 16'h1111},
        {3'd4, 16'h8421}, {3'd5, 16'h1041}, {3'd6, 16'h4081}, {3'd7, 16'h0101}
    };

    always #(CLK_PERIOD/2) clk = ~clk;

    clkdiv_sync u_clkdiv_sync (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .sync_in  (sync_in),
        .div_en_o (div_en_o),
        .realign_o(realign_o),
        .sticky_o (sticky_o)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    // one-cycle pulse; returns at the negedge following clock edge k+2
    task automatic pulse();
        sync_in = 1'b1;
        tick(1);
        sync_in = 1'b0;
        tick(2);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] d;
        int n;
        tick(3);
        rst = 1'b0;
        // R10 reset state
        rd(0, d); check("R10 ctrl", 16'(d), 16'h00);
        rd(1, d); check("R10 ratio", 16'(d), 16'h00);
        rd(2, d); check("R10 status", 16'(d), 16'h00);
        check("R10 div_en", 16'(div_en_o), 16'h1);
        check("R10 realign", 16'(realign_o), 16'h0);
        tick(1);

        // R1 register fields
        wr(0, 8'hFF); rd(0, d); check("R1 ctrl readback", 16'(d), 16'h07);
        wr(1, 8'hFF); rd(1, d); check("R1 ratio readback", 16'(d), 16'h07);
        rd(3, d); check("R1 addr3", 16'(d), 16'h00);
        wr(0, 8'h00);

        // R8 R7 R4 table of ratios in continuous mode
        wr(0, 8'h03);
        for (int v = 0; v < 8; v++) begin
            wr(1, {5'd0, VEC[v][18:16]});
            pulse();
            check("R7 realign pulse", 16'(realign_o), 16'h1);
            for (int i = 0; i < 16; i++) begin
                check("R8 enable pattern", 16'(div_en_o), 16'(VEC[v][i]));
                tick(1);
            end
        end
        check("R4 status after pulses", 16'(sticky_o), 16'h1);
        wr(1, 8'h03);
        pulse(); check("R4 second realign", 16'(realign_o), 16'h1);
        tick(1); check("R7 realign one cycle", 16'(realign_o), 16'h0);

        // R9 status clear semantics
        wr(2, 8'h00); check("R9 write zero keeps", 16'(sticky_o), 16'h1);
        wr(2, 8'h01); check("R9 write one clears", 16'(sticky_o), 16'h0);
        sync_in = 1'b1; tick(1); sync_in = 1'b0; tick(1);
        wr(2, 8'h01);
        check("R9 set beats clear", 16'(sticky_o), 16'h1);

        // R2 master off
        wr(0, 8'h02); wr(2, 8'h01);
        n = 0;
        sync_in = 1'b1; tick(1); sync_in = 1'b0;
        for (int i = 0; i < 6; i++) begin tick(1); if (realign_o) n++; end
        check("R2 no realign", 16'(n), 16'h0);
        check("R2 status untouched", 16'(sticky_o), 16'h0);

        // R3 master only
        wr(0, 8'h01);
        n = 0;
        sync_in = 1'b1; tick(1); sync_in = 1'b0;
        for (int i = 0; i < 6; i++) begin tick(1); if (realign_o) n++; end
        check("R3 gate off blocks", 16'(n), 16'h0);
        check("R3 status untouched", 16'(sticky_o), 16'h0);

        // R5 single shot
        wr(0, 8'h07);
        pulse(); check("R5 first realigns", 16'(realign_o), 16'h1);
        rd(0, d); check("R5 gate auto-cleared", 16'(d), 16'h05);
        tick(2); wr(2, 8'h01);
        n = 0;
        sync_in = 1'b1; tick(1); sync_in = 1'b0;
        for (int i = 0; i < 6; i++) begin tick(1); if (realign_o) n++; end
        check("R5 later ignored", 16'(n), 16'h0);
        check("R5 status stays clear", 16'(sticky_o), 16'h0);

        // R6 write wins over auto clear
        wr(0, 8'h07);
        sync_in = 1'b1; tick(1); sync_in = 1'b0; tick(1);
        wr(0, 8'h07);
        check("R6 realign seen", 16'(realign_o), 16'h1);
        rd(0, d); check("R6 gate kept", 16'(d), 16'h07);

        // R7 held level gives one realign
        wr(0, 8'h03); wr(2, 8'h01); tick(4);
        n = 0;
        sync_in = 1'b1;
        for (int i = 0; i < 12; i++) begin tick(1); if (realign_o) n++; end
        sync_in = 1'b0;
        check("R7 held level single", 16'(n), 16'h1);
        tick(4);

        // R10 reset mid-run
        wr(1, 8'h05); wr(0, 8'h07);
        rst = 1'b1; tick(2); rst = 1'b0;
        rd(0, d); check("R10 ctrl after reset", 16'(d), 16'h00);
        rd(1, d); check("R10 ratio after reset", 16'(d), 16'h00);
        check("R10 status after reset", 16'(sticky_o), 16'h0);
        check("R10 div_en after reset", 16'(div_en_o), 16'h1);
        tick(1);
        check("R8 ratio one every cycle", 16'(div_en_o), 16'h1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule